// File: doc/BRIEF.md
# Serial EEPROM Address Pointer with Write Lock

This block keeps the internal byte pointer of a two-wire serial EEPROM slave that holds 8192 bytes. The protocol engine hands it the two address bytes of a command as load strobes, and after every data byte it sends an increment strobe that says whether the byte was read or written. The pointer then moves to the next location under the rule of that transfer.

The two rules differ. A write advances only the five low bits, so a run of written bytes stays inside one 32-byte page and wraps to the start of that page. A read advances the whole 13-bit pointer and wraps from the top of the array back to zero. After a transfer the pointer rests on the address that follows the last byte used, so a later current-address read starts there. On the bus the pointer has no defined value after power-up. Here it resets to zero, and a random read (a dummy write of the address) is still what defines it.

The block also gives a per-byte write permission. While the protect input is high, the upper quarter of the array (6144 to 8191) may not be written. The flag is combinational from the live pin and the current pointer, so the protocol engine samples it as each byte is committed. A blocked byte is still acknowledged on the bus but is not stored. Reads never depend on the pin.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `addr_o` is 0.
- R2: A cycle with `ld_lo_i` high loads `addr_byte_i` into `addr_o[7:0]` on the next clock edge. `addr_o[12:8]` is unchanged unless `ld_hi_i` is also high.
- R3: A cycle with `ld_hi_i` high loads `addr_byte_i[4:0]` into `addr_o[12:8]`. `addr_byte_i[7:5]` is ignored, and `addr_o[7:0]` is unchanged unless `ld_lo_i` is also high. When both strobes are high, both fields load in the same edge.
- R4: A write increment (`inc_i`=1, `inc_rd_i`=0, no load) adds 1 modulo 32 to `addr_o[4:0]` and leaves `addr_o[12:5]` unchanged, so 31 in the page wraps to 0 of the same page.
- R5: A read increment (`inc_i`=1, `inc_rd_i`=1, no load) adds 1 modulo 8192 to the whole of `addr_o`, so 8191 becomes 0.
- R6: When a load strobe and `inc_i` are high in the same cycle, only the load takes effect.
- R7: With no strobe high, `addr_o` keeps its value.
- R8: `wr_ok_o` is 0 in the same cycle whenever `wp_i` is 1 and `addr_o[12:11]`=2'b11 (addresses 6144 to 8191). Otherwise it is 1. The pin is not latched.
- R9: `wp_i` has no effect on `addr_o`. A read increment or a load gives the same result with `wp_i` high as with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_hi_i | input | 1 | Load the high address byte |
| ld_lo_i | input | 1 | Load the low address byte |
| addr_byte_i | input | 8 | Received address byte |
| inc_i | input | 1 | Advance after a data byte |
| inc_rd_i | input | 1 | 1: the increment follows a read, 0: it follows a write |
| wp_i | input | 1 | Write-protect pin, live |
| addr_o | output | 13 | Current pointer |
| wr_ok_o | output | 1 | The byte at `addr_o` may be committed |

## Verification
On every cycle, the bound checker confirms the following:
- the page-local wrap of write increments, with the page bits held;
- the full-range step of read increments;
- both load fields, including that the three spare bits of the high byte are dropped;
- that the pointer holds when no strobe is high;
- the protection flag against the pin and the pointer.

Only the bench scenarios show the remaining cases:
- the exact wrap points at 31 within a page and at 8191;
- load winning over a simultaneous increment;
- that reads with the protect pin high land on the same addresses as reads with it low;
- the reset value.

// File: rtl/eap_pkg.sv
package eap_pkg;
  // kind of transfer that precedes an increment
  typedef enum logic {STEP_WRITE = 1'b0, STEP_READ = 1'b1} step_kind_e;
endpackage

// File: rtl/eap_next_calc.sv
module eap_next_calc #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        byte_i,
  input  logic              inc_i,
  input  logic              inc_rd_i,
  output logic [ADDR_W-1:0] rd_nxt_o,
  output logic [ADDR_W-1:0] wr_nxt_o,
  output logic [ADDR_W-1:0] nxt_o
);
  import eap_pkg::*;
  localparam int HI_W = ADDR_W - 8;

  // whole-array step, wraps at the top
  function automatic logic [ADDR_W-1:0] step_all(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // step inside the page, upper bits kept
  function automatic logic [ADDR_W-1:0] step_page(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  logic [ADDR_W-1:0] loaded;
  step_kind_e        kind;

  assign rd_nxt_o = step_all(cur_i);
  assign wr_nxt_o = step_page(cur_i);
  assign kind     = step_kind_e'(inc_rd_i);

  always_comb begin
    loaded = cur_i;
    if (ld_lo_i) loaded[7:0] = byte_i;
    if (ld_hi_i) loaded[ADDR_W-1:8] = byte_i[HI_W-1:0];
    if (ld_hi_i || ld_lo_i)      nxt_o = loaded;
    else if (inc_i)              nxt_o = (kind == STEP_READ) ? rd_nxt_o : wr_nxt_o;
    else                         nxt_o = cur_i;
  end
endmodule

// File: rtl/eap_ptr_reg.sv
module eap_ptr_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/eap_guard.sv
module eap_guard #(
  parameter int ADDR_W    = 13,
  parameter int LOCK_MSBS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  output logic              locked_o,
  output logic              wr_ok_o
);
  generate
    if (LOCK_MSBS == 0) begin : g_nolock
      assign locked_o = 1'b0;
    end else begin : g_lock
      // top 1/2^LOCK_MSBS of the array
      assign locked_o = &addr_i[ADDR_W-1 -: LOCK_MSBS];
    end
  endgenerate
  assign wr_ok_o = !(wp_i && locked_o);
endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 5,
  parameter int LOCK_MSBS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        addr_byte_i,
  input  logic              inc_i,
  input  logic              inc_rd_i,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_ok_o
);
  logic [ADDR_W-1:0] rd_nxt_w;
  logic [ADDR_W-1:0] wr_nxt_w;
  logic [ADDR_W-1:0] nxt_w;
  logic              locked_w;

  eap_next_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_calc (
    .cur_i(addr_o), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i), .byte_i(addr_byte_i),
    .inc_i(inc_i), .inc_rd_i(inc_rd_i),
    .rd_nxt_o(rd_nxt_w), .wr_nxt_o(wr_nxt_w), .nxt_o(nxt_w)
  );

  eap_ptr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .d_i(nxt_w), .q_o(addr_o)
  );

  eap_guard #(.ADDR_W(ADDR_W), .LOCK_MSBS(LOCK_MSBS)) u_guard (
    .addr_i(addr_o), .wp_i(wp_i), .locked_o(locked_w), .wr_ok_o(wr_ok_o)
  );
endmodule

// File: rtl/eap_chk.sv
module eap_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_hi_i,
  input logic              ld_lo_i,
  input logic [7:0]        addr_byte_i,
  input logic              inc_i,
  input logic              inc_rd_i,
  input logic              wp_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wr_ok_o
);
  logic any_ld;
  assign any_ld = ld_hi_i || ld_lo_i;

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> addr_o[7:0] == $past(addr_byte_i));
  // R3
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi_i |=> addr_o[ADDR_W-1:8] == $past(addr_byte_i[ADDR_W-9:0]));
  // R4
  wr_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !inc_rd_i && !any_ld) |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));
  // R4
  wr_low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !inc_rd_i && !any_ld) |=> addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1));
  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && inc_rd_i && !any_ld) |=> addr_o == ADDR_W'($past(addr_o) + 1));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !any_ld) |=> $stable(addr_o));
  // R8
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && addr_o[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !wr_ok_o);
  // R8
  lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_i || addr_o[ADDR_W-1:ADDR_W-2] != 2'b11) |-> wr_ok_o);
endmodule

bind eeprom_addr_ptr eap_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
  .addr_byte_i(addr_byte_i), .inc_i(inc_i), .inc_rd_i(inc_rd_i), .wp_i(wp_i),
  .addr_o(addr_o), .wr_ok_o(wr_ok_o)
);

// File: tb/sim_eeprom_addr_ptr.sv
module sim_eeprom_addr_ptr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_hi = 1'b0, ld_lo = 1'b0, inc = 1'b0, inc_rd = 1'b0, wp = 1'b0;
  logic [7:0]  abyte = 8'h00;
  logic [12:0] addr;
  logic        wr_ok;

  int n_chk = 0;
  int n_bad = 0;
  int ref_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_addr_ptr u0 (
    .clk(clk), .rst_n(rst_n), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo), .addr_byte_i(abyte),
    .inc_i(inc), .inc_rd_i(inc_rd), .wp_i(wp), .addr_o(addr), .wr_ok_o(wr_ok)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check flag before the edge, check pointer after
  task automatic step(input string tag, input bit h, input bit l, input int b,
                      input bit i, input bit r, input bit w);
    int nxt;
    ld_hi = h; ld_lo = l; abyte = 8'(b); inc = i; inc_rd = r; wp = w;
    #1;
    check(tag, "wr_ok", int'(wr_ok), (w && ref_addr >= 6144) ? 0 : 1);
    nxt = ref_addr;
    if (l) nxt = (nxt / 256) * 256 + b;
    if (h) nxt = (nxt % 256) + (b % 32) * 256;
    if (!(h || l) && i) begin
      if (r) nxt = (ref_addr + 1) % 8192;
      else   nxt = (ref_addr / 32) * 32 + ((ref_addr + 1) % 32);
    end
    @(posedge clk);
    ref_addr = nxt;
    @(negedge clk);
    check(tag, "addr", int'(addr), ref_addr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset value during and just after reset
    check("R1", "addr in reset", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "addr after reset", int'(addr), 0);
    check("R8", "wr_ok at zero", int'(wr_ok), 1);

    step("R2", 0, 1, 8'hA5, 0, 0, 0);
    step("R3", 1, 0, 8'hFF, 0, 0, 0);      // spare bits dropped: 0x1FA5
    step("R3", 1, 1, 8'h03, 0, 0, 0);      // both strobes, same byte
    step("R2", 0, 1, 8'h1E, 0, 0, 0);      // 0x031E
    for (int k = 0; k < 3; k++) step("R4", 0, 0, 0, 1, 0, 0); // 1F, wrap to 0300, 0301
    check("R4", "page wrap result", int'(addr), 13'h0301);

    step("R3", 1, 1, 8'h1F, 0, 0, 1);      // wp high, load unaffected: 0x1F1F
    step("R9", 0, 1, 8'hFE, 0, 0, 1);      // 0x1FFE
    for (int k = 0; k < 3; k++) step("R9", 0, 0, 0, 1, 1, 1); // FFF, 0, 1
    check("R5", "array wrap result", int'(addr), 1);
    step("R5", 0, 0, 0, 1, 1, 0);          // 2

    step("R6", 0, 1, 8'h10, 1, 1, 0);      // load wins
    check("R6", "load over inc", int'(addr), 16);
    step("R6", 1, 0, 8'h02, 1, 0, 0);      // 0x0210
    for (int k = 0; k < 4; k++) step("R7", 0, 0, 8'h55, 0, k[0], k[1]);

    step("R8", 1, 1, 8'h17, 0, 0, 1);      // 0x1717
    step("R8", 0, 1, 8'hFF, 0, 0, 1);      // 0x17FF writable
    step("R8", 0, 0, 0, 1, 1, 1);          // 0x1800 blocked
    step("R8", 0, 0, 0, 0, 0, 0);          // pin low: open
    step("R8", 0, 0, 0, 0, 0, 1);          // pin high again: blocked live
    step("R8", 1, 1, 8'hFF, 0, 0, 1);      // 0x1FFF
    step("R4", 0, 0, 0, 1, 0, 1);          // write wrap to 0x1FE0
    step("R8", 0, 0, 0, 0, 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule